// File: doc/BRIEF.md
# Key-Unlocked Independent Watchdog Timer

This block is a watchdog that runs from its own slow clock, apart from the system bus clock. It counts a 12-bit counter down and raises a system reset pulse when software stops refreshing it in time. Software reaches the block only through a write port on the bus clock, which has three addresses: a key address, a prescaler address and a reload address. Each write crosses into the watchdog clock through a toggle handshake. A busy flag on the bus side stays high until the write has arrived.

Fixed 16-bit key values start the watchdog, refresh it, and open the two configuration registers for writing. After a start, software has no way to stop the counter. The counter only ends by expiring. When it expires, the block drives its reset output for four watchdog cycles. It then puts itself back into its power-on state.

Top module: `keywdt_top`

## Requirements
- R1: Write addresses are 0 for the key, 1 for the prescaler (data bits 2:0) and 2 for the reload (data bits 11:0). Address 3 is ignored. A write is accepted only while `wr_busy` is low. `wr_busy` rises on the edge after an accepted write and falls once the write has reached the watchdog domain. A write made while `wr_busy` is high is discarded.
- R2: An accepted write takes effect on the third rising edge of `wd_clk` after the `bus_clk` edge that accepted it.
- R3: Key 0xCCCC written while the watchdog is idle starts it. The counter loads 0xFFF, whatever the reload register holds, and the prescaler clears.
- R4: While running, the counter drops by one every 4·2^P watchdog cycles, where P is the prescaler field. P values of 6 and 7 both give a divide by 256.
- R5: When the running counter holds 0, `wdt_rst` rises on the next `wd_clk` edge and stays high for exactly 4 cycles.
- R6: Key 0xAAAA written while running copies the reload value into the counter and restarts the prescaler. A reload value of 0 therefore fires the reset on the following edge.
- R7: Before a start, key 0xAAAA and all other keys leave `wdt_rst` low. Once running, no key value stops the counter, and 0xCCCC does not reload it.
- R8: Key 0x5555 unlocks the prescaler and reload registers. Any other key value locks them again. Prescaler or reload writes made while locked have no effect.
- R9: When the reset pulse ends, the block is idle and locked, with a prescaler of 0 and a reload of 0xFFF.
- R10: Counting and the reset pulse go on with no change while `bus_clk` is stopped.
- R11: After reset, `wdt_rst` and `wr_busy` are low and the watchdog is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 key, 1 prescaler, 2 reload) |
| wr_data | input | 16 | Write data |
| wr_busy | output | 1 | High while a write is still crossing |
| wd_clk | input | 1 | Independent low-speed watchdog clock |
| wd_rst | input | 1 | Synchronous active-high power-on reset, watchdog domain |
| wdt_rst | output | 1 | System reset pulse, 4 watchdog cycles |

## Verification
The bench goes after the following corner cases, each paired with the failure it would expose:
- **Crossing latency.** An off-by-one edge count in the crossing shifts every reset pulse in time, and the cycle-exact model would flag the shifted pulse.
- **Reload of zero.** A refresh with a reload of 0 must fire on the very next edge. A design that checks for zero before it loads would wait a full extra prescaler period.
- **Divide caps.** Prescaler values 6 and 7 must give equal timeouts. An uncapped divider would double the second timeout.
- **Start ignores reload.** A start must count from 0xFFF even when the reload register is small.
- **Restart after the pulse.** A restart after the pulse must see a reload of 0xFFF again. A design that kept its configuration across the self-reset would expire far too early.
- **Crossing while the bus clock is stopped.** A crossing that relied on bus-clock activity would fail to time out while the bus clock is held stopped.
- **Back-to-back writes.** A second write sent while busy is still high must be dropped, and only the first write may be applied.

// File: rtl/keywdt_pkg.sv
`timescale 1ns/1ps
package keywdt_pkg;

    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [1:0] {
        A_KEY    = 2'd0,
        A_PRESC  = 2'd1,
        A_RELOAD = 2'd2,
        A_SPARE  = 2'd3
    } wr_addr_e;

    typedef struct packed {
        wr_addr_e         addr;
        logic [KEY_W-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIRE
    } wd_state_e;

    // log2 of the prescaler divide: base shift plus the field, capped
    function automatic int unsigned div_exp(int unsigned pr, int unsigned cap,
                                            int unsigned base);
        return base + ((pr > cap) ? cap : pr);
    endfunction

endpackage

// File: rtl/keywdt_xfer.sv
`timescale 1ns/1ps
// Single-entry toggle-handshake carrier from the bus clock to the watchdog clock.
module keywdt_xfer #(
    parameter int PAY_W = 18,
    parameter int STG   = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [PAY_W-1:0] wr_payload,
    output logic             busy,
    input  logic             wd_clk,
    input  logic             wd_rst,
    output logic             land_valid,
    output logic [PAY_W-1:0] land_payload
);

    logic             req_q;
    logic [PAY_W-1:0] hold_q;
    logic [STG-1:0]   ack_sync_q;
    logic [STG-1:0]   req_sync_q;
    logic             seen_q;

    assign busy = req_q ^ ack_sync_q[STG-1];

    // bus side: capture payload, flip request, follow returned acknowledge
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_q      <= 1'b0;
            hold_q     <= '0;
            ack_sync_q <= '0;
        end else begin
            ack_sync_q <= {ack_sync_q[STG-2:0], seen_q};
            if (wr_en && !busy) begin
                hold_q <= wr_payload;
                req_q  <= ~req_q;
            end
        end
    end

    // watchdog side: synchronise request, detect its edge, echo as acknowledge
    always_ff @(posedge wd_clk) begin
        if (wd_rst) begin
            req_sync_q <= '0;
            seen_q     <= 1'b0;
        end else begin
            req_sync_q <= {req_sync_q[STG-2:0], req_q};
            seen_q     <= req_sync_q[STG-1];
        end
    end

    assign land_valid   = req_sync_q[STG-1] ^ seen_q;
    assign land_payload = hold_q;

    AST_BUSY_AFTER_WRITE: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && !busy) |=> busy); // R1

    AST_LAND_ONCE: assert property (@(posedge wd_clk) disable iff (wd_rst)
        land_valid |=> !land_valid); // R2

endmodule

// File: rtl/keywdt_cfg.sv
`timescale 1ns/1ps
// Key decoder and write-protected configuration registers (watchdog clock).
module keywdt_cfg
    import keywdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PR_W  = 3
) (
    input  logic             wd_clk,
    input  logic             wd_rst,
    input  logic             firing,
    input  logic             self_clr,
    input  logic             land_valid,
    input  wr_req_t          land_req,
    output logic             start_p,
    output logic             refresh_p,
    output logic [PR_W-1:0]  pr,
    output logic [CNT_W-1:0] reload
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    logic accept;
    logic unlock_q;

    assign accept    = land_valid && !firing;
    assign start_p   = accept && (land_req.addr == A_KEY) && (land_req.data == KEY_START);
    assign refresh_p = accept && (land_req.addr == A_KEY) && (land_req.data == KEY_REFRESH);

    always_ff @(posedge wd_clk) begin
        if (wd_rst || self_clr) begin
            unlock_q <= 1'b0;
            pr       <= '0;
            reload   <= RELOAD_RST;
        end else if (accept) begin
            case (land_req.addr)
                A_KEY:    unlock_q <= (land_req.data == KEY_UNLOCK);
                A_PRESC:  if (unlock_q) pr     <= land_req.data[PR_W-1:0];
                A_RELOAD: if (unlock_q) reload <= land_req.data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    AST_LOCKED_HOLD: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (accept && land_req.addr != A_KEY && !unlock_q) |=> ($stable(pr) && $stable(reload))); // R8

endmodule

// File: rtl/keywdt_count.sv
`timescale 1ns/1ps
// Prescaler, down-counter and reset-pulse sequencer (watchdog clock).
module keywdt_count
    import keywdt_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PR_W      = 3,
    parameter int PULSE_LEN = 4,
    parameter int BASE_LOG  = 2,
    parameter int PR_CAP    = 6
) (
    input  logic             wd_clk,
    input  logic             wd_rst,
    input  logic             start_p,
    input  logic             refresh_p,
    input  logic [PR_W-1:0]  pr,
    input  logic [CNT_W-1:0] reload,
    output logic             wdt_rst,
    output logic             firing,
    output logic             self_clr
);

    localparam int PCNT_W = BASE_LOG + PR_CAP;
    localparam int FC_W   = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;
    localparam logic [FC_W-1:0]  FC_LAST  = FC_W'(PULSE_LEN - 1);

    wd_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] pre_lim;
    logic [FC_W-1:0]   fcnt_q;
    logic              tick;

    // a divide of 2^PCNT_W wraps the shifted one to zero, leaving all ones
    always_comb begin
        pre_lim = (PCNT_W'(1) << div_exp(32'(pr), PR_CAP, BASE_LOG)) - PCNT_W'(1);
        tick    = (pcnt_q >= pre_lim);
    end

    always_ff @(posedge wd_clk) begin
        if (wd_rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_TOP;
            pcnt_q  <= '0;
            fcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_p) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CNT_TOP;
                        pcnt_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_FIRE;
                        fcnt_q  <= '0;
                    end else if (refresh_p) begin
                        cnt_q  <= reload;
                        pcnt_q <= '0;
                    end else if (tick) begin
                        pcnt_q <= '0;
                        cnt_q  <= cnt_q - CNT_W'(1);
                    end else begin
                        pcnt_q <= pcnt_q + PCNT_W'(1);
                    end
                end
                ST_FIRE: begin
                    if (fcnt_q == FC_LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= CNT_TOP;
                        pcnt_q  <= '0;
                        fcnt_q  <= '0;
                    end else begin
                        fcnt_q <= fcnt_q + FC_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign firing   = (state_q == ST_FIRE);
    assign wdt_rst  = firing;
    assign self_clr = firing && (fcnt_q == FC_LAST);

    AST_FIRE_FROM_ZERO: assert property (@(posedge wd_clk) disable iff (wd_rst)
        $rose(wdt_rst) |-> $past(state_q == ST_RUN && cnt_q == '0)); // R5

    AST_PULSE_HOLD: assert property (@(posedge wd_clk) disable iff (wd_rst)
        $rose(wdt_rst) |=> wdt_rst); // R5

    AST_RUN_STICKY: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (state_q == ST_RUN) |=> (state_q != ST_IDLE)); // R7

    AST_REFRESH_LOAD: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (state_q == ST_RUN && cnt_q != '0 && refresh_p) |=> (cnt_q == $past(reload) && pcnt_q == '0)); // R6

    AST_CLEAN_AFTER_PULSE: assert property (@(posedge wd_clk) disable iff (wd_rst)
        $fell(wdt_rst) |-> (pr == '0 && reload == CNT_TOP && state_q == ST_IDLE)); // R9

endmodule

// File: rtl/keywdt_top.sv
`timescale 1ns/1ps
module keywdt_top
    import keywdt_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PR_W      = 3,
    parameter int PULSE_LEN = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    output logic             wr_busy,
    input  logic             wd_clk,
    input  logic             wd_rst,
    output logic             wdt_rst
);

    localparam int PAY_W = $bits(wr_req_t);

    wr_req_t          req_in;
    wr_req_t          land_req;
    logic [PAY_W-1:0] land_vec;
    logic             land_valid;
    logic             start_p;
    logic             refresh_p;
    logic [PR_W-1:0]  pr;
    logic [CNT_W-1:0] reload;
    logic             firing;
    logic             self_clr;

    assign req_in.addr = wr_addr_e'(wr_addr);
    assign req_in.data = wr_data;
    assign land_req    = wr_req_t'(land_vec);

    keywdt_xfer #(.PAY_W(PAY_W), .STG(SYNC_STG)) u_xfer (
        .bus_clk      (bus_clk),
        .bus_rst      (bus_rst),
        .wr_en        (wr_en),
        .wr_payload   (req_in),
        .busy         (wr_busy),
        .wd_clk       (wd_clk),
        .wd_rst       (wd_rst),
        .land_valid   (land_valid),
        .land_payload (land_vec)
    );

    keywdt_cfg #(.CNT_W(CNT_W), .PR_W(PR_W)) u_cfg (
        .wd_clk     (wd_clk),
        .wd_rst     (wd_rst),
        .firing     (firing),
        .self_clr   (self_clr),
        .land_valid (land_valid),
        .land_req   (land_req),
        .start_p    (start_p),
        .refresh_p  (refresh_p),
        .pr         (pr),
        .reload     (reload)
    );

    keywdt_count #(.CNT_W(CNT_W), .PR_W(PR_W), .PULSE_LEN(PULSE_LEN)) u_count (
        .wd_clk    (wd_clk),
        .wd_rst    (wd_rst),
        .start_p   (start_p),
        .refresh_p (refresh_p),
        .pr        (pr),
        .reload    (reload),
        .wdt_rst   (wdt_rst),
        .firing    (firing),
        .self_clr  (self_clr)
    );

endmodule

// File: tb/keywdt_top_test.sv
`timescale 1ns/1ps
module keywdt_top_test;

    logic        bus_clk = 1'b0;
    logic        wd_clk  = 1'b0;
    logic        bus_run = 1'b1;
    logic        bus_rst = 1'b1;
    logic        wd_rst  = 1'b1;
    logic        wr_en   = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wr_busy;
    logic        wdt_rst;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    keywdt_top uut (
        .bus_clk (bus_clk), .bus_rst (bus_rst), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_busy (wr_busy),
        .wd_clk  (wd_clk),  .wd_rst  (wd_rst),  .wdt_rst (wdt_rst)
    );

    // 50 MHz bus clock that can be held low; slower offset watchdog clock
    always #10 if (bus_run || bus_clk) bus_clk = ~bus_clk;
    initial begin
        #5;
        forever #20 wd_clk = ~wd_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int q_age[$];
    int q_addr[$];
    int q_data[$];
    int m_state = 0;   // 0 idle, 1 running, 2 pulsing
    int m_cnt = 4095, m_pcnt = 0, m_fire = 0, m_pr = 0, m_rl = 4095, m_unl = 0;

    always @(posedge wd_clk) begin : model
        bit lv;
        int la, ld, div, old_rl;
        bit st, rf;
        if (wd_rst) begin
            m_state = 0; m_cnt = 4095; m_pcnt = 0; m_fire = 0;
            m_pr = 0; m_rl = 4095; m_unl = 0;
            q_age.delete(); q_addr.delete(); q_data.delete();
        end else begin
            lv = 0; la = 0; ld = 0;
            foreach (q_age[i]) q_age[i]++;
            if (q_age.size() > 0 && q_age[0] >= 3) begin
                lv = 1;
                la = q_addr.pop_front();
                ld = q_data.pop_front();
                void'(q_age.pop_front());
            end
            if (m_state == 2) begin
                if (m_fire == 3) begin
                    m_state = 0; m_cnt = 4095; m_pcnt = 0;
                    m_pr = 0; m_rl = 4095; m_unl = 0;
                end else m_fire++;
            end else begin
                st = lv && la == 0 && ld == 16'hCCCC;
                rf = lv && la == 0 && ld == 16'hAAAA;
                old_rl = m_rl;
                div = 4 << ((m_pr > 6) ? 6 : m_pr);
                if (m_state == 0) begin
                    if (st) begin m_state = 1; m_cnt = 4095; m_pcnt = 0; end
                end else if (m_cnt == 0) begin
                    m_state = 2; m_fire = 0;
                end else if (rf) begin
                    m_cnt = old_rl; m_pcnt = 0;
                end else if (m_pcnt >= div - 1) begin
                    m_pcnt = 0; m_cnt--;
                end else m_pcnt++;
                if (lv) begin
                    case (la)
                        0: m_unl = (ld == 16'h5555) ? 1 : 0;
                        1: if (m_unl != 0) m_pr = ld & 7;
                        2: if (m_unl != 0) m_rl = ld & 4095;
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison of the reset output (R5 timing, covers R2..R10)
    always @(negedge wd_clk) begin
        if (!wd_rst && !done)
            chk(wdt_rst === (m_state == 2), "R5 cycle compare", int'(wdt_rst), int'(m_state == 2));
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_put(input int a, input int d, output bit acc);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        acc = !wr_busy;
        @(posedge bus_clk);
        #1;
        if (acc) begin q_age.push_back(0); q_addr.push_back(a); q_data.push_back(d); end
        wr_en = 1'b0;
    endtask

    task automatic wait_free();
        int n = 0;
        do begin @(negedge bus_clk); n++; end while (wr_busy && n < 200);
        chk(!wr_busy, "R1 busy clears", int'(wr_busy), 0);
    endtask

    task automatic bus_write(input int a, input int d);
        bit acc;
        bus_put(a, d, acc);
        wait_free();
    endtask

    task automatic wait_rise(input int max, output int n);
        n = 0;
        while (!wdt_rst && n < max) begin @(negedge wd_clk); n++; end
    endtask

    task automatic wait_pulse_end();
        int n = 0;
        while (wdt_rst && n < 20) begin @(negedge wd_clk); n++; end
        repeat (2) @(negedge wd_clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #3_600_000;
        chk(0, "WATCHDOG timeout", 0, 1);
        finish_up();
    end

    // ---------------- test sequence ----------------
    initial begin
        int n, n6, n7, hi;
        bit acc1, acc2;
        repeat (6) @(negedge wd_clk);
        bus_rst = 1'b0;
        wd_rst  = 1'b0;
        repeat (3) @(negedge wd_clk);

        // R11: reset state
        chk(wdt_rst == 1'b0, "R11 reset wdt_rst", int'(wdt_rst), 0);
        chk(wr_busy == 1'b0, "R11 reset busy", int'(wr_busy), 0);

        // R7: keys before start do nothing
        bus_write(0, 16'hAAAA);
        bus_write(0, 16'h0000);
        repeat (100) @(negedge wd_clk);
        chk(wdt_rst == 1'b0, "R7 idle refresh ignored", int'(wdt_rst), 0);

        // R8: locked writes ignored, unlock, relock
        bus_write(2, 5);
        bus_write(1, 6);
        bus_write(0, 16'h5555);
        bus_write(1, 1);
        bus_write(2, 3);
        bus_write(0, 16'h1234);
        bus_write(2, 100);
        bus_write(0, 16'hCCCC);
        bus_write(0, 16'hAAAA);
        wait_rise(200, n);
        chk(wdt_rst == 1'b1, "R8 reload 3 prescale 1 timeout", n, 25);
        chk(n < 60, "R8 relock kept reload 3", n, 25);
        // R5: pulse width
        hi = 0;
        while (wdt_rst && hi < 20) begin @(negedge wd_clk); hi++; end
        chk(hi == 4, "R5 pulse width", hi, 4);
        repeat (2) @(negedge wd_clk);

        // R9: after the pulse the reload is 0xFFF again
        bus_write(0, 16'hCCCC);
        bus_write(0, 16'hAAAA);
        wait_rise(17000, n);
        chk(wdt_rst == 1'b1 && n > 16000, "R9 reload back to 0xFFF", n, 16380);
        wait_pulse_end();

        // R3: start counts from 0xFFF even with a small reload
        bus_write(0, 16'h5555);
        bus_write(2, 2);
        bus_write(0, 16'hCCCC);
        wait_rise(17000, n);
        chk(wdt_rst == 1'b1 && n > 16000, "R3 start from 0xFFF", n, 16380);
        wait_pulse_end();

        // R4: prescaler values 6 and 7 give the same divide
        bus_write(0, 16'h5555); bus_write(1, 6); bus_write(2, 2);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        wait_rise(2000, n6);
        wait_pulse_end();
        bus_write(0, 16'h5555); bus_write(1, 7); bus_write(2, 2);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        wait_rise(2000, n7);
        chk(n6 == n7, "R4 divide cap 6 vs 7", n7, n6);
        chk(n6 > 500 && n6 < 530, "R4 divide by 256", n6, 512);
        wait_pulse_end();

        // R6: repeated refreshes keep it alive
        bus_write(0, 16'h5555); bus_write(2, 10);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        for (int k = 0; k < 5; k++) begin
            repeat (20) @(negedge wd_clk);
            bus_write(0, 16'hAAAA);
        end
        chk(wdt_rst == 1'b0, "R6 refresh prevents reset", int'(wdt_rst), 0);
        // R6 + R2: reload 0 fires one edge after landing, landing on third edge
        bus_write(0, 16'h5555);
        bus_write(2, 0);
        bus_put(0, 16'hAAAA, acc1);
        repeat (3) @(posedge wd_clk);
        @(negedge wd_clk);
        chk(wdt_rst == 1'b0, "R2 not before landing", int'(wdt_rst), 0);
        @(posedge wd_clk);
        @(negedge wd_clk);
        chk(wdt_rst == 1'b1, "R6 reload zero fires next edge", int'(wdt_rst), 1);
        wait_pulse_end();
        repeat (300) @(negedge wd_clk);
        chk(wdt_rst == 1'b0, "R9 idle after pulse", int'(wdt_rst), 0);

        // R7: running counter not stopped or reloaded by keys
        bus_write(0, 16'h5555); bus_write(2, 50);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        bus_write(0, 16'h0000); bus_write(0, 16'h1234); bus_write(0, 16'hCCCC);
        wait_rise(400, n);
        chk(wdt_rst == 1'b1 && n < 300, "R7 keys do not stop counter", n, 170);
        wait_pulse_end();

        // R1: write while busy is discarded; address 3 ignored
        bus_write(0, 16'h5555);
        bus_put(2, 7, acc1);
        chk(wr_busy == 1'b1, "R1 busy after write", int'(wr_busy), 1);
        bus_put(2, 9, acc2);
        chk(acc1 && !acc2, "R1 second write rejected", int'(acc2), 0);
        wait_free();
        bus_write(3, 16'h0001);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        wait_rise(200, n);
        chk(wdt_rst == 1'b1 && n < 40, "R1 reload 7 applied", n, 25);
        wait_pulse_end();

        // R10: bus clock stopped during countdown
        bus_write(0, 16'h5555); bus_write(1, 2); bus_write(2, 20);
        bus_write(0, 16'hCCCC); bus_write(0, 16'hAAAA);
        @(negedge bus_clk);
        bus_run = 1'b0;
        wait_rise(1000, n);
        chk(wdt_rst == 1'b1, "R10 fires with bus clock stopped", n, 320);
        hi = 0;
        while (wdt_rst && hi < 20) begin @(negedge wd_clk); hi++; end
        chk(hi == 4, "R10 pulse width with bus clock stopped", hi, 4);
        bus_run = 1'b1;
        repeat (10) @(negedge wd_clk);

        finish_up();
    end

endmodule